// File: doc/BRIEF.md
# Tolerant framing reference matcher

This block finds where a text service begins on a video line. The serial data slicer hands it one bit per sample strobe. The block keeps the most recent bits in a 24-bit history and, on every strobe, compares that history against a programmable reference. The reference covers the run-in pattern and the framing code.

The reference is split into three 8-bit segments. Each segment has its own limit on how many bit errors it may carry and still count as matching. A per-bit mask removes positions from the comparison. Services whose run-in is shorter than 16 bits can therefore match on fewer bits.

Searching starts on a line-start pulse and stops at the first match or when a programmed window of strobes runs out. A match gives a one-cycle lock pulse. It also raises a payload enable that stays high until the next line-start pulse, together with a payload bit index. The index places byte alignment on the bit that follows the last reference bit.

Top module: `frame_ref_matcher`

## Requirements
- R1: After reset, `lock_o` and `payload_en_o` are low, and no match is reported until the first `line_start_i` pulse arms a search.
- R2: The history is ordered so that the most recently received bit lines up with `ref_i[0]`, and the bit received 23 strobes earlier lines up with `ref_i[23]`. Segment k covers bits 8k+7..8k and uses the tolerance field `tol_i[4k+3:4k]`.
- R3: A match occurs when, in every segment, the number of unmasked positions where history and reference differ is less than or equal to that segment's tolerance. `lock_o` is high in the cycle after the matching strobe.
- R4: A position whose `mask_i` bit is 0 never counts as an error. A position whose mask bit is 1 may only match once a bit has actually been received into it since line start, so a 16-bit mask can match after only 16 strobes.
- R5: Only the first match in a line is reported. Later occurrences of the pattern give no further `lock_o` until the next `line_start_i`.
- R6: A match is accepted only on strobes 1 through `win_len_i` counted from line start. When `win_len_i` is 0, no match is accepted.
- R7: `lock_o` is a single-cycle pulse. `payload_en_o` rises together with it and stays high until a `line_start_i` pulse.
- R8: `payload_idx_o` is 0 in the lock cycle and advances by one, modulo 8, on each later strobe while `payload_en_o` is high.
- R9: `line_start_i` clears `lock_o`, `payload_en_o` and the history in the next cycle, and any strobe in the same cycle is discarded.
- R10: A cycle without a strobe or line start leaves `payload_en_o` unchanged and gives no `lock_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | Start-of-line pulse, arms a search |
| bit_valid_i | input | 1 | Sample strobe for `bit_i` |
| bit_i | input | 1 | Serial sliced data bit |
| ref_i | input | 24 | Reference pattern, bit 23 oldest |
| mask_i | input | 24 | Compare enable per reference bit |
| tol_i | input | 12 | Three 4-bit per-segment error limits |
| win_len_i | input | 8 | Search window in strobes after line start |
| lock_o | output | 1 | One-cycle match pulse |
| payload_en_o | output | 1 | High from match until next line start |
| payload_idx_o | output | 3 | Bit position within the payload byte of the next strobe |

## Verification
The bench targets the following corner cases. If errors were counted across the whole reference instead of per segment, a flipped bit in a segment with zero tolerance would still lock. A wrong history order would move such an error into the wrong segment. If filled positions were not tracked, a full mask against a mostly zero reference would lock on the cleared history before 24 bits had arrived. The window edge is tested on both sides at exactly 24 strobes and at zero. A repeated pattern after a lock must give no second pulse. A line start that coincides with a strobe must drop that bit, which removes exactly the oldest reference bit and so prevents the lock. Random lines with random masks, tolerances and bit flips are checked against a bench model on every strobe and idle cycle.

// File: rtl/frm_pkg.sv
`timescale 1ns/1ps
package frm_pkg;
  localparam int unsigned DEF_SEG_W = 8;
  localparam int unsigned DEF_NSEG  = 3;
  localparam int unsigned DEF_TOL_W = 4;
  localparam int unsigned DEF_WIN_W = 8;
endpackage

// File: rtl/frm_seg_check.sv
`timescale 1ns/1ps
module frm_seg_check #(
  parameter int unsigned SEG_W = frm_pkg::DEF_SEG_W,
  parameter int unsigned TOL_W = frm_pkg::DEF_TOL_W
) (
  input  logic [SEG_W-1:0] data_i,
  input  logic [SEG_W-1:0] ref_i,
  input  logic [SEG_W-1:0] mask_i,
  input  logic [SEG_W-1:0] fill_i,
  input  logic [TOL_W-1:0] tol_i,
  output logic             ok_o
);
  localparam int unsigned POP_W = $clog2(SEG_W + 1);
  localparam int unsigned CW    = (POP_W > TOL_W) ? POP_W : TOL_W;

  logic [SEG_W-1:0] err;
  logic [CW-1:0]    err_cnt;
  logic             unfilled;

  always_comb begin
    err      = (data_i ^ ref_i) & mask_i;
    unfilled = |(mask_i & ~fill_i);
    err_cnt  = '0;
    for (int i = 0; i < SEG_W; i++) err_cnt = err_cnt + CW'(err[i]);
    ok_o = !unfilled && (err_cnt <= CW'(tol_i));
  end
endmodule

// File: rtl/frm_search_ctrl.sv
`timescale 1ns/1ps
module frm_search_ctrl #(
  parameter int unsigned WIN_W = frm_pkg::DEF_WIN_W,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             strobe_i,
  input  logic             match_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             lock_o,
  output logic             pay_en_o,
  output logic [IDX_W-1:0] pay_idx_o
);
  logic [WIN_W-1:0] cnt;
  logic [WIN_W:0]   cnt_nx;
  logic             armed;
  logic             hit;

  assign cnt_nx = {1'b0, cnt} + {{WIN_W{1'b0}}, 1'b1};
  assign hit    = armed && strobe_i && match_i && (cnt < win_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      armed     <= 1'b0;
      lock_o    <= 1'b0;
      pay_en_o  <= 1'b0;
      pay_idx_o <= '0;
    end else if (line_start_i) begin
      cnt       <= '0;
      armed     <= 1'b1;
      lock_o    <= 1'b0;
      pay_en_o  <= 1'b0;
      pay_idx_o <= '0;
    end else begin
      lock_o <= hit;
      if (strobe_i) begin
        if (pay_en_o) pay_idx_o <= pay_idx_o + 1'b1;
        if (hit) begin
          armed     <= 1'b0;
          pay_en_o  <= 1'b1;
          pay_idx_o <= '0;
        end else if (armed && (cnt_nx >= {1'b0, win_len_i})) begin
          armed <= 1'b0;  // window exhausted
        end
        if (armed) cnt <= cnt_nx[WIN_W-1:0];
      end
    end
  end

  // R7
  lock_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> !lock_o);
  // R7
  lock_pay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> pay_en_o);
  // R7
  pay_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_en_o && !line_start_i) |=> pay_en_o);
  // R5
  single_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_en_o && !line_start_i) |=> !lock_o);
  // R9
  line_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (!pay_en_o && !lock_o));
  // R8
  idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (pay_idx_o == '0));
endmodule

// File: rtl/frame_ref_matcher.sv
`timescale 1ns/1ps
module frame_ref_matcher #(
  parameter int unsigned SEG_W = frm_pkg::DEF_SEG_W,
  parameter int unsigned NSEG  = frm_pkg::DEF_NSEG,
  parameter int unsigned TOL_W = frm_pkg::DEF_TOL_W,
  parameter int unsigned WIN_W = frm_pkg::DEF_WIN_W,
  localparam int unsigned REF_W = SEG_W * NSEG,
  localparam int unsigned IDX_W = (SEG_W > 1) ? $clog2(SEG_W) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_start_i,
  input  logic                  bit_valid_i,
  input  logic                  bit_i,
  input  logic [REF_W-1:0]      ref_i,
  input  logic [REF_W-1:0]      mask_i,
  input  logic [NSEG*TOL_W-1:0] tol_i,
  input  logic [WIN_W-1:0]      win_len_i,
  output logic                  lock_o,
  output logic                  payload_en_o,
  output logic [IDX_W-1:0]      payload_idx_o
);
  logic [REF_W-1:0] hist_q, fill_q;
  logic [REF_W-1:0] hist_nx, fill_nx;
  logic [NSEG-1:0]  seg_ok;
  logic             strobe;

  assign strobe  = bit_valid_i && !line_start_i;
  assign hist_nx = {hist_q[REF_W-2:0], bit_i};
  assign fill_nx = {fill_q[REF_W-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (line_start_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (strobe) begin
      hist_q <= hist_nx;
      fill_q <= fill_nx;
    end
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    frm_seg_check #(.SEG_W(SEG_W), .TOL_W(TOL_W)) u_seg (
      .data_i (hist_nx[k*SEG_W +: SEG_W]),
      .ref_i  (ref_i[k*SEG_W +: SEG_W]),
      .mask_i (mask_i[k*SEG_W +: SEG_W]),
      .fill_i (fill_nx[k*SEG_W +: SEG_W]),
      .tol_i  (tol_i[k*TOL_W +: TOL_W]),
      .ok_o   (seg_ok[k])
    );
  end

  frm_search_ctrl #(.WIN_W(WIN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .strobe_i    (strobe),
    .match_i     (&seg_ok),
    .win_len_i   (win_len_i),
    .lock_o      (lock_o),
    .pay_en_o    (payload_en_o),
    .pay_idx_o   (payload_idx_o)
  );

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && !line_start_i) |=> ($stable(payload_en_o) && !lock_o));
  // R3
  lock_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(bit_valid_i && !line_start_i));
endmodule

// File: tb/frame_ref_matcher_test.sv
`timescale 1ns/1ps
module frame_ref_matcher_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_start = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [23:0] ref_v = '0;
  logic [23:0] mask_v = '0;
  logic [11:0] tol_v = '0;
  logic [7:0]  win_v = '0;
  logic        lock_o, payload_en_o;
  logic [2:0]  payload_idx_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  logic [23:0] m_hist, m_fill;
  int          m_cnt;
  bit          m_armed = 0, m_pay = 0, m_lock = 0;
  int          m_idx = 0;

  always #10 clk = ~clk;

  frame_ref_matcher uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start),
    .bit_valid_i(bit_valid), .bit_i(bit_in), .ref_i(ref_v), .mask_i(mask_v),
    .tol_i(tol_v), .win_len_i(win_v), .lock_o(lock_o),
    .payload_en_o(payload_en_o), .payload_idx_o(payload_idx_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_match();
    logic [23:0] e, miss;
    e    = (m_hist ^ ref_v) & mask_v;
    miss = mask_v & ~m_fill;
    for (int k = 0; k < 3; k++) begin
      if (miss[8*k +: 8] != 8'h00) return 0;
      if ($countones(e[8*k +: 8]) > int'(tol_v[4*k +: 4])) return 0;
    end
    return 1;
  endfunction

  task automatic model_step(input logic b);
    bit was_pay;
    was_pay = m_pay;
    m_hist  = {m_hist[22:0], b};
    m_fill  = {m_fill[22:0], 1'b1};
    m_lock  = 0;
    if (was_pay) m_idx = (m_idx + 1) % 8;
    if (m_armed) begin
      m_cnt++;
      if (m_cnt <= int'(win_v) && model_match()) begin
        m_lock = 1; m_armed = 0; m_pay = 1; m_idx = 0;
      end else if (m_cnt >= int'(win_v)) begin
        m_armed = 0;
      end
    end
  endtask

  task automatic compare_outputs();
    chk("R3/R4/R5/R6 lock", lock_o, m_lock);
    chk("R7 payload_en", payload_en_o, m_pay);
    if (m_pay) chk("R8 payload_idx", payload_idx_o, m_idx);
  endtask

  task automatic idle_cycle();
    bit_valid = 0; line_start = 0;
    @(negedge clk);
    m_lock = 0;
    chk("R10 idle lock", lock_o, 0);
    chk("R10 idle payload_en", payload_en_o, m_pay);
  endtask

  task automatic send_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) idle_cycle();
    bit_valid = 1; bit_in = b; line_start = 0;
    model_step(b);
    @(negedge clk);
    bit_valid = 0;
    compare_outputs();
  endtask

  task automatic send_ref(input int nbits, input int gap);
    for (int i = nbits - 1; i >= 0; i--) send_bit(ref_v[i], gap);
  endtask

  task automatic line_begin(input logic with_strobe);
    line_start = 1; bit_valid = with_strobe; bit_in = ref_v[23];
    @(negedge clk);
    line_start = 0; bit_valid = 0;
    m_hist = '0; m_fill = '0; m_cnt = 0; m_armed = 1;
    m_pay = 0; m_lock = 0; m_idx = 0;
    chk("R9 line start lock", lock_o, 0);
    chk("R9 line start payload_en", payload_en_o, 0);
  endtask

  task automatic cfg(input logic [23:0] r, input logic [23:0] m,
                     input logic [11:0] t, input logic [7:0] w);
    ref_v = r; mask_v = m; tol_v = t; win_v = w;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_hist = '0; m_fill = '0; m_cnt = 0;
    cfg(24'h5555_27, 24'hFFFFFF, 12'h000, 8'd40);
    repeat (3) @(negedge clk);
    chk("R1 reset lock", lock_o, 0);
    chk("R1 reset payload_en", payload_en_o, 0);
    rst_ni = 1;
    @(negedge clk);
    // R1: no search before first line start
    send_ref(24, 0);
    chk("R1 unarmed lock", lock_o, 0);
    chk("R1 unarmed payload_en", payload_en_o, 0);

    // R3 exact match, then payload index alignment (R8)
    line_begin(0);
    send_ref(24, 1);
    chk("R3 exact lock", lock_o, 1);
    chk("R8 idx at lock", payload_idx_o, 0);
    for (int i = 0; i < 3; i++) send_bit(1'($urandom_range(0, 1)), 0);
    chk("R8 idx after 3", payload_idx_o, 3);
    for (int i = 0; i < 5; i++) send_bit(1'($urandom_range(0, 1)), 0);
    chk("R8 idx after 8", payload_idx_o, 0);
    // R5 repeated pattern ignored
    send_ref(24, 0);
    chk("R5 second pattern lock", lock_o, 0);
    chk("R7 payload_en held", payload_en_o, 1);
    idle_cycle();

    // R3 one error in oldest segment tolerated by tol field [11:8]
    cfg(24'h5555_27, 24'hFFFFFF, 12'h100, 8'd40);
    line_begin(0);
    for (int i = 23; i >= 0; i--) send_bit(ref_v[i] ^ (i == 20), 0);
    chk("R3 tolerated error lock", lock_o, 1);
    // R3 same error, zero tolerance
    cfg(24'h5555_27, 24'hFFFFFF, 12'h000, 8'd40);
    line_begin(0);
    for (int i = 23; i >= 0; i--) send_bit(ref_v[i] ^ (i == 20), 0);
    chk("R3 excess error lock", lock_o, 0);
    // R2 error in newest segment is not covered by oldest segment's tolerance
    cfg(24'h5555_27, 24'hFFFFFF, 12'h100, 8'd40);
    line_begin(0);
    for (int i = 23; i >= 0; i--) send_bit(ref_v[i] ^ (i == 3), 0);
    chk("R2 segment placement lock", lock_o, 0);

    // R4 short mask locks after 16 bits
    cfg(24'h5555_27, 24'h00FFFF, 12'h000, 8'd40);
    line_begin(0);
    send_ref(16, 0);
    chk("R4 short mask lock", lock_o, 1);
    // R4 full mask cannot match cleared history
    cfg(24'h0000_27, 24'hFFFFFF, 12'h000, 8'd40);
    line_begin(0);
    send_ref(16, 0);
    chk("R4 unfilled no lock", lock_o, 0);
    // R4 masked positions carry errors freely
    cfg(24'h5555_27, 24'h00FFFF, 12'h000, 8'd40);
    line_begin(0);
    for (int i = 23; i >= 0; i--) send_bit((i >= 16) ? ~ref_v[i] : ref_v[i], 0);
    chk("R4 masked errors", m_lock || payload_en_o, 1);

    // R6 window edges
    cfg(24'h5555_27, 24'hFFFFFF, 12'h000, 8'd23);
    line_begin(0);
    send_ref(24, 0);
    chk("R6 window short lock", lock_o, 0);
    cfg(24'h5555_27, 24'hFFFFFF, 12'h000, 8'd24);
    line_begin(0);
    send_ref(24, 0);
    chk("R6 window exact lock", lock_o, 1);
    cfg(24'h000000, 24'h000000, 12'h000, 8'd0);
    line_begin(0);
    send_bit(1'b0, 0);
    chk("R6 zero window lock", lock_o, 0);

    // R9 strobe coinciding with line start is dropped
    cfg(24'h5555_27, 24'hFFFFFF, 12'h000, 8'd40);
    line_begin(1);
    for (int i = 22; i >= 0; i--) send_bit(ref_v[i], 0);
    chk("R9 dropped strobe lock", lock_o, 0);
    // R9 line start clears payload
    line_begin(0);
    send_ref(24, 0);
    line_begin(0);
    chk("R9 cleared payload_en", payload_en_o, 0);

    // random lines against the model
    for (int ln = 0; ln < 40; ln++) begin
      logic [23:0] m;
      case ($urandom_range(0, 2))
        0: m = 24'hFFFFFF;
        1: m = 24'h00FFFF;
        default: m = 24'hFFFFFF >> $urandom_range(0, 12);
      endcase
      cfg(24'($urandom), m,
          {4'($urandom_range(0, 2)), 4'($urandom_range(0, 2)), 4'($urandom_range(0, 2))},
          8'($urandom_range(16, 50)));
      line_begin(1'($urandom_range(0, 3) == 0));
      for (int i = 0; i < int'($urandom_range(0, 8)); i++)
        send_bit(1'($urandom_range(0, 1)), $urandom_range(0, 1));
      for (int rep = 0; rep < 1 + int'($urandom_range(0, 1)); rep++)
        for (int i = 23; i >= 0; i--)
          send_bit(ref_v[i] ^ ($urandom_range(0, 15) == 0), $urandom_range(0, 2));
      for (int i = 0; i < 16; i++)
        send_bit(1'($urandom_range(0, 1)), $urandom_range(0, 1));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule